// File: doc/BRIEF.md
# Branch, Call and Return Sequencer

This block chooses the next program counter for the program-flow instructions of a 16-bit core. It is handed one instruction word at a time, together with the ALU flags, the contents of the register named as the jump target and the already incremented program counter. For a jump it selects either the target or the fall-through address. For a call or return it also moves a return address on a stack kept in ordinary data memory. The stack pointer lives in general register rE, which the block reads and writes through a dedicated port, and the stack grows toward lower addresses.

Software must load the target register before any jump or call, and it must set rE to 16'hFFFF before the first call. A taken call decrements the stack pointer and then writes the return address at the new pointer. A return reads the word at the pointer and then increments it. While a stack memory cycle is in progress the block raises busy and ignores any new instruction. The fetch stage waits for the one-cycle next-PC strobe before it continues.

Top module: `flow_seq`

## Requirements
- R1: Bits 15:12 of the instruction word hold the opcode and bits 11:8 hold the condition code. Bits 7:0 of a jump or call, and bits 11:0 of a return, have no effect on any output.
- R2: Condition code 0 always holds. Codes 1, 2, 3 and 4 hold when flags_i bit 0 (zero), bit 1 (sign), bit 2 (carry) or bit 3 (overflow) is set, in that order. Codes 5 to 15 never hold.
- R3: A jump (opcode 4'hC) accepted at an edge raises npc_valid_o for exactly one cycle after that edge. npc_o is target_i when the condition holds and pc_inc_i when it does not. The jump makes no memory access and no stack-pointer write.
- R4: A call (opcode 4'hD) whose condition holds keeps busy_o high for one cycle after acceptance. In that cycle it writes pc_inc_i to address sp_i-1 and writes sp_i-1 back through sp_o/sp_we_o. In the following cycle npc_valid_o is high and npc_o equals the latched target.
- R5: A call whose condition fails behaves like an untaken jump. npc_o is pc_inc_i one cycle after acceptance, with no memory access and no stack-pointer write.
- R6: A return (opcode 4'hE) reads memory at sp_i in the first cycle after acceptance. In the second cycle it writes sp_i+1 through sp_we_o. In the third cycle npc_valid_o is high, with npc_o equal to the word that was read. Calls nested three deep unwind in order and leave rE back at 16'hFFFF.
- R7: busy_o is high in every stack memory cycle. An instruction presented while busy_o is high is ignored.
- R8: An instruction with any opcode other than the three flow opcodes produces no next-PC strobe, no memory access, no stack-pointer write and no busy cycle.
- R9: After reset, npc_valid_o, busy_o, mem_we_o, mem_re_o and sp_we_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction word present this cycle |
| instr_i | input | 16 | Instruction word |
| flags_i | input | 4 | Flags: bit0 zero, bit1 sign, bit2 carry, bit3 overflow |
| target_i | input | 16 | Contents of the target register |
| pc_inc_i | input | 16 | Program counter plus one |
| sp_i | input | 16 | Current value of rE |
| sp_o | output | 16 | New value for rE |
| sp_we_o | output | 1 | Write strobe for rE |
| mem_addr_o | output | 16 | Stack memory address |
| mem_wdata_o | output | 16 | Stack memory write data |
| mem_we_o | output | 1 | Stack memory write strobe |
| mem_re_o | output | 1 | Stack memory read strobe (data returned next cycle) |
| mem_rdata_i | input | 16 | Stack memory read data |
| busy_o | output | 1 | Stack cycle in progress |
| npc_valid_o | output | 1 | Next program counter valid |
| npc_o | output | 16 | Next program counter |

## Verification
A corrupted latched stack pointer shows up within the same instruction. The write address, the rE write-back value or the read address is then off by one, and in the bench the stack-pointer value after every call and return is compared against a running model. A wrong latched return address or target shows up either on npc_o in the strobe cycle or, for a push, as a bad return value three instructions later when the nested returns unwind. A stuck or skipped state changes the strobe latency (one, two or three cycles) or leaves busy_o high, and each row's latency is measured exactly.

// File: rtl/flow_pkg.sv
package flow_pkg;
  localparam int unsigned FLAG_Z = 0;
  localparam int unsigned FLAG_S = 1;
  localparam int unsigned FLAG_C = 2;
  localparam int unsigned FLAG_V = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_POP  = 2'd2,
    ST_LOAD = 2'd3
  } stk_state_e;
endpackage

// File: rtl/flow_cond_eval.sv
module flow_cond_eval #(
  parameter int unsigned NF = 4,
  parameter int unsigned CW = 4
) (
  input  logic [CW-1:0] cc_i,
  input  logic [NF-1:0] flags_i,
  output logic          take_o
);
  logic [NF-1:0] hit;

  // code k+1 selects flag k; code 0 is always; the rest never
  for (genvar k = 0; k < NF; k++) begin : g_flag
    assign hit[k] = (cc_i == CW'(k + 1)) & flags_i[k];
  end

  assign take_o = (cc_i == '0) | (|hit);
endmodule

// File: rtl/flow_stack_ctrl.sv
module flow_stack_ctrl
  import flow_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_req_i,
  input  logic          pop_req_i,
  input  logic [DW-1:0] sp_i,
  input  logic [DW-1:0] ret_addr_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_we_o,
  output logic          mem_re_o,
  output logic [DW-1:0] sp_o,
  output logic          sp_we_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          done_pop_o,
  output logic [DW-1:0] pop_data_o
);
  stk_state_e    state_q, state_d;
  logic [DW-1:0] sp_q, ret_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (push_req_i)     state_d = ST_PUSH;
        else if (pop_req_i) state_d = ST_POP;
      end
      ST_PUSH: state_d = ST_IDLE;
      ST_POP:  state_d = ST_LOAD;
      ST_LOAD: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sp_q    <= '0;
      ret_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && push_req_i) begin
        sp_q  <= sp_i - DW'(1);   // pre-decrement
        ret_q <= ret_addr_i;
      end else if (state_q == ST_IDLE && pop_req_i) begin
        sp_q  <= sp_i;
      end
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign mem_we_o    = (state_q == ST_PUSH);
  assign mem_re_o    = (state_q == ST_POP);
  assign mem_addr_o  = sp_q;
  assign mem_wdata_o = ret_q;
  assign sp_we_o     = (state_q == ST_PUSH) | (state_q == ST_LOAD);
  assign sp_o        = (state_q == ST_LOAD) ? sp_q + DW'(1) : sp_q;
  assign done_o      = (state_q == ST_PUSH) | (state_q == ST_LOAD);
  assign done_pop_o  = (state_q == ST_LOAD);
  assign pop_data_o  = mem_rdata_i;

  AST_NO_REENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |-> !(push_req_i || pop_req_i)); // R7

  AST_PUSH_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !busy_o); // R4

  AST_READ_THEN_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> (busy_o && sp_we_o && !mem_re_o)); // R6

  AST_MEM_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o)); // R7
endmodule

// File: rtl/flow_seq.sv
module flow_seq
  import flow_pkg::*;
#(
  parameter int unsigned DW      = 16,
  parameter int unsigned IW      = 16,
  parameter int unsigned NF      = 4,
  parameter logic [3:0]  OP_JMP  = 4'hC,
  parameter logic [3:0]  OP_CALL = 4'hD,
  parameter logic [3:0]  OP_RET  = 4'hE
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          instr_valid_i,
  input  logic [IW-1:0] instr_i,
  input  logic [NF-1:0] flags_i,
  input  logic [DW-1:0] target_i,
  input  logic [DW-1:0] pc_inc_i,
  input  logic [DW-1:0] sp_i,
  output logic [DW-1:0] sp_o,
  output logic          sp_we_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_we_o,
  output logic          mem_re_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          busy_o,
  output logic          npc_valid_o,
  output logic [DW-1:0] npc_o
);
  localparam int unsigned OP_LSB = IW - 4;
  localparam int unsigned CC_LSB = IW - 8;

  logic [3:0] op;
  logic [3:0] cc;
  logic       accept, is_jmp, is_call, is_ret, take;
  logic       push_req, pop_req, stk_done, stk_done_pop;
  logic [DW-1:0] pop_data, tgt_q, npc_q;
  logic          npc_valid_q;

  assign op      = instr_i[OP_LSB +: 4];
  assign cc      = instr_i[CC_LSB +: 4];
  assign accept  = instr_valid_i & ~busy_o;
  assign is_jmp  = (op == OP_JMP);
  assign is_call = (op == OP_CALL);
  assign is_ret  = (op == OP_RET);

  flow_cond_eval #(.NF(NF), .CW(4)) u_cond (
    .cc_i    (cc),
    .flags_i (flags_i),
    .take_o  (take)
  );

  assign push_req = accept & is_call & take;
  assign pop_req  = accept & is_ret;

  flow_stack_ctrl #(.DW(DW)) u_stk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_req_i  (push_req),
    .pop_req_i   (pop_req),
    .sp_i        (sp_i),
    .ret_addr_i  (pc_inc_i),
    .mem_rdata_i (mem_rdata_i),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_we_o    (mem_we_o),
    .mem_re_o    (mem_re_o),
    .sp_o        (sp_o),
    .sp_we_o     (sp_we_o),
    .busy_o      (busy_o),
    .done_o      (stk_done),
    .done_pop_o  (stk_done_pop),
    .pop_data_o  (pop_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      npc_valid_q <= 1'b0;
      npc_q       <= '0;
      tgt_q       <= '0;
    end else begin
      npc_valid_q <= 1'b0;
      if (accept && (is_jmp || (is_call && !take))) begin
        npc_valid_q <= 1'b1;
        npc_q       <= (is_jmp && take) ? target_i : pc_inc_i;
      end else if (push_req) begin
        tgt_q <= target_i;
      end else if (stk_done) begin
        npc_valid_q <= 1'b1;
        npc_q       <= stk_done_pop ? pop_data : tgt_q;
      end
    end
  end

  assign npc_valid_o = npc_valid_q;
  assign npc_o       = npc_q;

  AST_PUSH_SP_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (sp_we_o && sp_o == sp_i - DW'(1) && mem_addr_o == sp_o)); // R4

  AST_POP_SP_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sp_we_o && !mem_we_o) |-> (sp_o == sp_i + DW'(1))); // R6

  AST_UNTAKEN_CALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && is_call && !take) |=> (!busy_o && npc_valid_o && npc_o == $past(pc_inc_i))); // R5

  AST_IGNORED_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !is_jmp && !is_call && !is_ret) |=> (!npc_valid_o && !busy_o && !sp_we_o)); // R8

  AST_JMP_NO_STACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && is_jmp) |=> (npc_valid_o && !busy_o && !mem_we_o && !mem_re_o)); // R3
endmodule

// File: tb/flow_seq_bench.sv
`timescale 1ns/1ps
module flow_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        instr_valid = 1'b0;
  logic [15:0] instr = '0, target = '0, pc_inc = '0;
  logic [3:0]  flags = '0;
  logic [15:0] sp_o, mem_addr, mem_wdata, npc;
  logic        sp_we, mem_we, mem_re, busy, npc_valid;
  logic [15:0] rdata;
  logic [15:0] re_q;
  logic [15:0] mem [64];

  int errors = 0;
  int checks = 0;

  flow_seq u_flow_seq (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(instr_valid), .instr_i(instr),
    .flags_i(flags), .target_i(target), .pc_inc_i(pc_inc), .sp_i(re_q),
    .sp_o(sp_o), .sp_we_o(sp_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_we_o(mem_we), .mem_re_o(mem_re), .mem_rdata_i(rdata), .busy_o(busy),
    .npc_valid_o(npc_valid), .npc_o(npc)
  );

  // register rE, initialised by "software" to FFFF
  always @(posedge clk or negedge rst_n)
    if (!rst_n) re_q <= 16'hFFFF;
    else if (sp_we) re_q <= sp_o;

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;
    if (mem_re) rdata <= mem[mem_addr[5:0]];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [15:0] ins;
    logic [3:0]  flg;
    logic [15:0] tgt;
    logic [15:0] pci;
    logic [15:0] enpc;
    logic [1:0]  elat;   // 0: no strobe expected
    logic [15:0] esp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{16'hC0AB, 4'h0, 16'h0100, 16'h0011, 16'h0100, 2'd1, 16'hFFFF, 4'd1}, // R1 jump always, low bits ignored
    '{16'hC100, 4'h0, 16'h0200, 16'h0012, 16'h0012, 2'd1, 16'hFFFF, 4'd2}, // R2 zero untaken
    '{16'hC1FF, 4'h1, 16'h0200, 16'h0013, 16'h0200, 2'd1, 16'hFFFF, 4'd2}, // R2 zero taken
    '{16'hC200, 4'h1, 16'h0300, 16'h0014, 16'h0014, 2'd1, 16'hFFFF, 4'd2}, // R2 sign untaken
    '{16'hC200, 4'h2, 16'h0300, 16'h0015, 16'h0300, 2'd1, 16'hFFFF, 4'd2}, // R2 sign taken
    '{16'hC300, 4'hB, 16'h0400, 16'h0016, 16'h0016, 2'd1, 16'hFFFF, 4'd2}, // R2 carry untaken
    '{16'hC300, 4'h4, 16'h0400, 16'h0017, 16'h0400, 2'd1, 16'hFFFF, 4'd2}, // R2 carry taken
    '{16'hC400, 4'h7, 16'h0500, 16'h0018, 16'h0018, 2'd1, 16'hFFFF, 4'd2}, // R2 overflow untaken
    '{16'hC400, 4'h8, 16'h0500, 16'h0019, 16'h0500, 2'd1, 16'hFFFF, 4'd3}, // R3 overflow taken
    '{16'hC500, 4'hF, 16'h0600, 16'h001A, 16'h001A, 2'd1, 16'hFFFF, 4'd2}, // R2 code 5 never
    '{16'hCF00, 4'hF, 16'h0600, 16'h001B, 16'h001B, 2'd1, 16'hFFFF, 4'd3}, // R3 code F never
    '{16'hD100, 4'h0, 16'h0700, 16'h0050, 16'h0050, 2'd1, 16'hFFFF, 4'd5}, // R5 call untaken
    '{16'hD0EE, 4'h0, 16'h1000, 16'h0051, 16'h1000, 2'd2, 16'hFFFE, 4'd4}, // R4 call depth 1
    '{16'hD100, 4'h1, 16'h2000, 16'h1001, 16'h2000, 2'd2, 16'hFFFD, 4'd4}, // R4 call depth 2
    '{16'hD400, 4'h8, 16'h3000, 16'h2001, 16'h3000, 2'd2, 16'hFFFC, 4'd4}, // R4 call depth 3
    '{16'hE123, 4'h0, 16'h9999, 16'h3001, 16'h2001, 2'd3, 16'hFFFD, 4'd1}, // R1 ret, bits 11:0 ignored
    '{16'hEFFF, 4'hF, 16'h9999, 16'h2002, 16'h1001, 2'd3, 16'hFFFE, 4'd6}, // R6
    '{16'hE000, 4'h0, 16'h9999, 16'h1002, 16'h0051, 2'd3, 16'hFFFF, 4'd6}, // R6 back to FFFF
    '{16'h6918, 4'hF, 16'h0800, 16'h0060, 16'h0000, 2'd0, 16'hFFFF, 4'd8}, // R8 other opcode
    '{16'hD700, 4'hF, 16'h0900, 16'h0061, 16'h0061, 2'd1, 16'hFFFF, 4'd5}  // R5 reserved code
  };

  task automatic run_vec(input vec_t v);
    int lat = 0, pulses = 0;
    bit we_seen = 0, re_seen = 0, spw_seen = 0, busy_seen = 0;
    logic [15:0] got = '0, we_a = '0, we_d = '0, re_a = '0;
    string rq;
    rq = $sformatf("R%0d", v.req);
    @(negedge clk);
    instr = v.ins; flags = v.flg; target = v.tgt; pc_inc = v.pci; instr_valid = 1'b1;
    for (int n = 1; n <= 5; n++) begin
      @(negedge clk);
      if (n == 1) instr_valid = 1'b0;
      if (busy) busy_seen = 1;
      if (mem_we) begin we_seen = 1; we_a = mem_addr; we_d = mem_wdata; end
      if (mem_re) begin re_seen = 1; re_a = mem_addr; end
      if (sp_we) spw_seen = 1;
      if (npc_valid) begin
        pulses++;
        if (lat == 0) begin lat = n; got = npc; end
      end
    end
    chk(lat == int'(v.elat) && pulses == (v.elat != 0 ? 1 : 0), rq, "strobe latency",
        16'(lat), 16'(v.elat));
    if (v.elat != 0) chk(got == v.enpc, rq, "next pc", got, v.enpc);
    chk(re_q == v.esp, rq, "stack pointer", re_q, v.esp);
    chk(we_seen == (v.elat == 2) && re_seen == (v.elat == 3) && spw_seen == (v.elat >= 2)
        && busy_seen == (v.elat >= 2), rq, "stack activity",
        16'({we_seen, re_seen, spw_seen, busy_seen}),
        16'({v.elat == 2, v.elat == 3, v.elat >= 2, v.elat >= 2}));
    if (v.elat == 2) begin
      chk(we_a == v.esp, "R4", "push address", we_a, v.esp);
      chk(we_d == v.pci, "R4", "push data", we_d, v.pci);
    end
    if (v.elat == 3) chk(re_a == v.esp - 16'd1, "R6", "pop address", re_a, v.esp - 16'd1);
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!npc_valid && !busy && !mem_we && !mem_re && !sp_we, "R9", "outputs in reset",
        16'({npc_valid, busy, mem_we, mem_re, sp_we}), 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!npc_valid && !busy && !mem_we && !mem_re && !sp_we, "R9", "outputs after reset",
        16'({npc_valid, busy, mem_we, mem_re, sp_we}), 16'h0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R7: jump offered during the push cycle is ignored
    @(negedge clk);
    instr = 16'hD000; flags = 4'h0; target = 16'h4000; pc_inc = 16'h0077; instr_valid = 1'b1;
    @(negedge clk);
    chk(busy, "R7", "busy in push cycle", 16'(busy), 16'h1);
    instr = 16'hC000; target = 16'h5555; pc_inc = 16'h0088;
    @(negedge clk);
    instr_valid = 1'b0;
    chk(npc_valid && npc == 16'h4000, "R7", "call result", npc, 16'h4000);
    @(negedge clk);
    chk(!npc_valid, "R7", "ignored jump produced no strobe", 16'(npc_valid), 16'h0);
    @(negedge clk);
    chk(!npc_valid && !busy, "R7", "idle after ignore", 16'({npc_valid, busy}), 16'h0);
    run_vec('{16'hE000, 4'h0, 16'h0, 16'h0, 16'h0077, 2'd3, 16'hFFFF, 4'd7}); // R7 unwind

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule